// File: doc/BRIEF.md
# Fault timing and latch supervisor

This block sits between the analog protection comparators of a six-bridge power driver and the gate control that switches each high-side and low-side transistor. It turns raw level flags for supply undervoltage, per-switch overcurrent, thermal prewarning and thermal shutdown into timed, latched fault status bits and into the masks that switch the output stages off. Every delay is counted in ticks of an internal prescaler, so the same logic serves any system clock.

Each fault class has its own recovery rule. An undervoltage that outlasts its delay cuts every output and raises a sticky supply-fail bit, but the outputs return as soon as the supply is good again. A short that outlasts its delay switches off only the switch concerned and raises a sticky short bit; that switch stays off until software writes a status reset. A thermal shutdown cuts every output and forces all status bits high; it is released only once the shutdown flag has cleared and a status reset has also been written. The status-reset pulse and the delay-select bit come from the committed control word.

Top module: `protSupervisor`

## Requirements
- R1: After reset every status output (supplyFail, shortSeen, tempWarn, overTemp) is 0, both per-switch disable masks are 0 and killAll is 0.
- R2: While uvFlag stays high for UV_TICKS prescaler ticks, killAll rises and supplyFail is set; neither is asserted if uvFlag is held for fewer than UV_TICKS-1 tick periods.
- R3: When uvFlag falls, killAll is released in the same cycle (unless a thermal latch holds it), while supplyFail stays 1 until a statusReset pulse clears it on the next clock edge.
- R4: An overcurrent flag held on switch i (bit i of ocHigh or ocLow) for the programmed delay sets bit i of the matching disable mask (hsOff for ocHigh, lsOff for ocLow) and sets shortSeen; no other mask bit and not killAll is affected.
- R5: delaySel = 0 selects a delay of SC_SHORT_TICKS ticks and delaySel = 1 a delay of SC_LONG_TICKS ticks.
- R6: An overcurrent flag that falls before its delay expires returns that switch's timer to zero, so a reasserted flag needs a full new delay.
- R7: A statusReset pulse clears shortSeen and every bit of hsOff and lsOff on the next clock edge.
- R8: tempWarn follows tpFlag with one clock cycle of latency, both rising and falling.
- R9: One cycle after tsdFlag rises, overTemp is 1, supplyFail, shortSeen and tempWarn all read 1, and killAll is 1.
- R10: A statusReset while tsdFlag is still high leaves the thermal latch set; once tsdFlag is low, a statusReset releases overTemp and killAll on the next edge.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| uvFlag | input | 1 | Supply undervoltage comparator flag |
| ocHigh | input | NUM_BRIDGES | Overcurrent flag per high-side switch |
| ocLow | input | NUM_BRIDGES | Overcurrent flag per low-side switch |
| tpFlag | input | 1 | Thermal prewarning comparator flag |
| tsdFlag | input | 1 | Thermal shutdown comparator flag |
| delaySel | input | 1 | Short-circuit delay select: 1 long, 0 short |
| statusReset | input | 1 | One-cycle status reset strobe from the committed control word |
| supplyFail | output | 1 | Sticky supply-fail status bit |
| shortSeen | output | 1 | Sticky short-circuit status bit |
| tempWarn | output | 1 | Thermal prewarning status bit |
| overTemp | output | 1 | Thermal shutdown latch status bit |
| hsOff | output | NUM_BRIDGES | High-side switches disabled by a short |
| lsOff | output | NUM_BRIDGES | Low-side switches disabled by a short |
| killAll | output | 1 | Global disable of every output stage |

## Verification
The bench builds the block with a prescale of 4 and delays of 5, 3 and 8 ticks for undervoltage, short and long short-circuit timing, which brings every timer expiry within a few dozen cycles while keeping the short and long delays far enough apart that a check at the short window proves the long delay is still running. Each timing check brackets expiry: no fault one tick before the earliest possible expiry, fault present shortly after the latest one, which holds whatever the prescaler phase is. The small delay values also make the interrupted-overcurrent case observable, since the accumulated flag time exceeds the delay while no single run does.

// File: rtl/protSupPkg.sv
package protSupPkg;

  // Strobes passed from the timer control to the latch datapath
  typedef struct packed {
    logic uvExpired;      // undervoltage held for the full delay (level)
    logic clrStatus;      // status reset accepted
    logic releaseThermal; // status reset with shutdown flag already clear
  } supStrobe_t;

endpackage

// File: rtl/protTick.sv
module protTick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : gNoDiv
      assign tick = 1'b1;
    end else begin : gDiv
      localparam int PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] psCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             psCnt <= '0;
        else if (psCnt == LAST) psCnt <= '0;
        else                   psCnt <= psCnt + 1'b1;
      end
      assign tick = (psCnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/protTimers.sv
module protTimers
  import protSupPkg::*;
#(
  parameter int NUM_SW         = 12,
  parameter int UV_TICKS       = 5,
  parameter int SC_SHORT_TICKS = 3,
  parameter int SC_LONG_TICKS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              uvFlag,
  input  logic [NUM_SW-1:0] ocAll,
  input  logic [NUM_SW-1:0] swOffNow,
  input  logic              delaySel,
  input  logic              statusReset,
  input  logic              tsdFlag,
  output logic [NUM_SW-1:0] scExpire,
  output supStrobe_t        strobes
);
  localparam int MAX_T  = (UV_TICKS > SC_LONG_TICKS) ?
                          ((UV_TICKS > SC_SHORT_TICKS) ? UV_TICKS : SC_SHORT_TICKS) :
                          ((SC_LONG_TICKS > SC_SHORT_TICKS) ? SC_LONG_TICKS : SC_SHORT_TICKS);
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] UV_LIM    = CNT_W'(UV_TICKS);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SC_SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(SC_LONG_TICKS);

  // Undervoltage timer
  logic [CNT_W-1:0] uvCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      uvCnt <= '0;
    else if (!uvFlag)               uvCnt <= '0;
    else if (tick && uvCnt < UV_LIM) uvCnt <= uvCnt + 1'b1;
  end

  // Short-circuit delay limit from the select bit
  logic [CNT_W-1:0] scLimit;
  assign scLimit = delaySel ? LONG_LIM : SHORT_LIM;

  // One timer per switch
  genvar i;
  generate
    for (i = 0; i < NUM_SW; i++) begin : gSw
      logic [CNT_W-1:0] scCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          scCnt <= '0;
        else if (!ocAll[i] || swOffNow[i])  scCnt <= '0;
        else if (tick && scCnt < scLimit)   scCnt <= scCnt + 1'b1;
      end
      assign scExpire[i] = ocAll[i] && !swOffNow[i] && (scCnt >= scLimit);
    end
  endgenerate

  always_comb begin
    strobes.uvExpired      = uvFlag && (uvCnt == UV_LIM);
    strobes.clrStatus      = statusReset;
    strobes.releaseThermal = statusReset && !tsdFlag;
  end
endmodule

// File: rtl/protLatches.sv
module protLatches
  import protSupPkg::*;
#(
  parameter int NUM_SW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  supStrobe_t        strobes,
  input  logic [NUM_SW-1:0] scExpire,
  input  logic              tpFlag,
  input  logic              tsdFlag,
  output logic [NUM_SW-1:0] swOffNow,
  output logic              psfOut,
  output logic              scdOut,
  output logic              tpOut,
  output logic              tsdOut,
  output logic              killOut
);
  logic psfReg, scdReg, tpReg, tsdReg;
  logic [NUM_SW-1:0] swOffReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psfReg   <= 1'b0;
      scdReg   <= 1'b0;
      tpReg    <= 1'b0;
      tsdReg   <= 1'b0;
      swOffReg <= '0;
    end else begin
      tpReg <= tpFlag;
      // sticky supply fail: a persisting fault wins over a clear
      if (strobes.uvExpired)      psfReg <= 1'b1;
      else if (strobes.clrStatus) psfReg <= 1'b0;
      if (|scExpire)              scdReg <= 1'b1;
      else if (strobes.clrStatus) scdReg <= 1'b0;
      if (strobes.clrStatus)      swOffReg <= scExpire;
      else                        swOffReg <= swOffReg | scExpire;
      if (tsdFlag)                     tsdReg <= 1'b1;
      else if (strobes.releaseThermal) tsdReg <= 1'b0;
    end
  end

  assign swOffNow = swOffReg;
  assign psfOut   = psfReg | tsdReg;
  assign scdOut   = scdReg | tsdReg;
  assign tpOut    = tpReg  | tsdReg;
  assign tsdOut   = tsdReg;
  assign killOut  = tsdReg | strobes.uvExpired;
endmodule

// File: rtl/protSupervisor.sv
module protSupervisor
  import protSupPkg::*;
#(
  parameter int NUM_BRIDGES    = 6,
  parameter int PRESCALE       = 1000,
  parameter int UV_TICKS       = 10,
  parameter int SC_SHORT_TICKS = 2,
  parameter int SC_LONG_TICKS  = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   uvFlag,
  input  logic [NUM_BRIDGES-1:0] ocHigh,
  input  logic [NUM_BRIDGES-1:0] ocLow,
  input  logic                   tpFlag,
  input  logic                   tsdFlag,
  input  logic                   delaySel,
  input  logic                   statusReset,
  output logic                   supplyFail,
  output logic                   shortSeen,
  output logic                   tempWarn,
  output logic                   overTemp,
  output logic [NUM_BRIDGES-1:0] hsOff,
  output logic [NUM_BRIDGES-1:0] lsOff,
  output logic                   killAll
);
  localparam int NUM_SW = 2 * NUM_BRIDGES;

  logic              tick;
  logic [NUM_SW-1:0] scExpire;
  logic [NUM_SW-1:0] swOffNow;
  supStrobe_t        strobes;

  protTick #(.PRESCALE(PRESCALE)) uTick (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  protTimers #(
    .NUM_SW(NUM_SW), .UV_TICKS(UV_TICKS),
    .SC_SHORT_TICKS(SC_SHORT_TICKS), .SC_LONG_TICKS(SC_LONG_TICKS)
  ) uTimers (
    .clk(clk), .rstN(rstN), .tick(tick), .uvFlag(uvFlag),
    .ocAll({ocLow, ocHigh}), .swOffNow(swOffNow), .delaySel(delaySel),
    .statusReset(statusReset), .tsdFlag(tsdFlag),
    .scExpire(scExpire), .strobes(strobes)
  );

  protLatches #(.NUM_SW(NUM_SW)) uLatches (
    .clk(clk), .rstN(rstN), .strobes(strobes), .scExpire(scExpire),
    .tpFlag(tpFlag), .tsdFlag(tsdFlag), .swOffNow(swOffNow),
    .psfOut(supplyFail), .scdOut(shortSeen), .tpOut(tempWarn),
    .tsdOut(overTemp), .killOut(killAll)
  );

  assign hsOff = swOffNow[NUM_BRIDGES-1:0];
  assign lsOff = swOffNow[NUM_SW-1:NUM_BRIDGES];
endmodule

// File: rtl/protSupervisorChk.sv
module protSupervisorChk #(
  parameter int NUM_BRIDGES = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   uvFlag,
  input logic [NUM_BRIDGES-1:0] ocHigh,
  input logic [NUM_BRIDGES-1:0] ocLow,
  input logic                   tpFlag,
  input logic                   tsdFlag,
  input logic                   delaySel,
  input logic                   statusReset,
  input logic                   supplyFail,
  input logic                   shortSeen,
  input logic                   tempWarn,
  input logic                   overTemp,
  input logic [NUM_BRIDGES-1:0] hsOff,
  input logic [NUM_BRIDGES-1:0] lsOff,
  input logic                   killAll
);
  // R3
  psf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyFail) |-> $past(statusReset));

  // R3
  uv_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!uvFlag && !overTemp) |-> !killAll);

  // R7
  scd_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shortSeen) |-> $past(statusReset));

  // R4
  hs_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hsOff & ~$past(hsOff) & ~$past(ocHigh)) == '0));

  // R4
  ls_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((lsOff & ~$past(lsOff) & ~$past(ocLow)) == '0));

  // R9
  tsd_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tsdFlag |=> (overTemp && killAll && supplyFail && shortSeen && tempWarn));

  // R10
  tsd_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overTemp) |-> $past(statusReset && !tsdFlag));

  // R8
  tp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !overTemp |-> (tempWarn == $past(tpFlag)));

  logic unusedSel;
  assign unusedSel = delaySel;
endmodule

bind protSupervisor protSupervisorChk #(.NUM_BRIDGES(NUM_BRIDGES)) uChk (.*);

// File: tb/protSupervisor_test.sv
`timescale 1ns/1ps
module protSupervisor_test;
  localparam int NB  = 6;
  localparam int P   = 4;
  localparam int UVT = 5;
  localparam int SCS = 3;
  localparam int SCL = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvFlag = 1'b0, tpFlag = 1'b0, tsdFlag = 1'b0, delaySel = 1'b0, statusReset = 1'b0;
  logic [NB-1:0] ocHigh = '0, ocLow = '0;
  logic supplyFail, shortSeen, tempWarn, overTemp, killAll;
  logic [NB-1:0] hsOff, lsOff;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  protSupervisor #(
    .NUM_BRIDGES(NB), .PRESCALE(P), .UV_TICKS(UVT),
    .SC_SHORT_TICKS(SCS), .SC_LONG_TICKS(SCL)
  ) uut (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseReset();
    statusReset = 1'b1;
    cyc(1);
    statusReset = 1'b0;
  endtask

  task automatic testReset();
    chk(supplyFail == 0 && shortSeen == 0 && tempWarn == 0 && overTemp == 0,
        "R1 status", {supplyFail, shortSeen, tempWarn, overTemp}, 0);
    chk(hsOff == 0 && lsOff == 0 && killAll == 0, "R1 masks", {hsOff, lsOff, killAll}, 0);
  endtask

  task automatic testUv();
    uvFlag = 1'b1;
    cyc((UVT - 1) * P);
    chk(killAll == 0 && supplyFail == 0, "R2 early", {killAll, supplyFail}, 0);
    cyc(2 * P + 2);
    chk(killAll == 1 && supplyFail == 1, "R2 expired", {killAll, supplyFail}, 3);
    uvFlag = 1'b0;
    #1;
    chk(killAll == 0, "R3 immediate release", killAll, 0);
    cyc(3);
    chk(supplyFail == 1, "R3 sticky", supplyFail, 1);
    pulseReset();
    chk(supplyFail == 0, "R3 cleared", supplyFail, 0);
  endtask

  task automatic testShortHs();
    delaySel = 1'b0;
    ocHigh = 6'b000100;
    cyc((SCS - 1) * P);
    chk(hsOff == 0 && shortSeen == 0, "R5 short early", hsOff, 0);
    cyc(2 * P + 2);
    chk(hsOff == 6'b000100, "R4 hs mask", hsOff, 6'b000100);
    chk(lsOff == 0 && killAll == 0 && shortSeen == 1, "R4 others", {lsOff, killAll, shortSeen}, 1);
    ocHigh = '0;
    cyc(3);
    chk(hsOff == 6'b000100, "R4 held", hsOff, 6'b000100);
    pulseReset();
    chk(hsOff == 0 && shortSeen == 0, "R7 cleared", {hsOff, shortSeen}, 0);
  endtask

  task automatic testShortLong();
    delaySel = 1'b1;
    ocLow = 6'b100000;
    cyc((SCL - 1) * P);
    chk(lsOff == 0 && shortSeen == 0, "R5 long early", lsOff, 0);
    cyc(2 * P + 2);
    chk(lsOff == 6'b100000 && hsOff == 0, "R5 long expired", lsOff, 6'b100000);
    ocLow = '0;
    delaySel = 1'b0;
    pulseReset();
    chk(lsOff == 0 && shortSeen == 0, "R7 ls cleared", {lsOff, shortSeen}, 0);
  endtask

  task automatic testGlitch();
    delaySel = 1'b0;
    ocLow = 6'b000001;
    cyc((SCS - 1) * P);
    ocLow = '0;
    cyc(2);
    ocLow = 6'b000001;
    cyc((SCS - 1) * P);
    chk(lsOff == 0 && shortSeen == 0, "R6 timer restarted", lsOff, 0);
    cyc(2 * P + 2);
    chk(lsOff == 6'b000001, "R6 full delay", lsOff, 1);
    ocLow = '0;
    pulseReset();
    chk(lsOff == 0, "R7 after glitch", lsOff, 0);
  endtask

  task automatic testTp();
    tpFlag = 1'b1;
    #1;
    chk(tempWarn == 0, "R8 not yet", tempWarn, 0);
    cyc(1);
    chk(tempWarn == 1, "R8 rise", tempWarn, 1);
    tpFlag = 1'b0;
    cyc(1);
    chk(tempWarn == 0, "R8 fall", tempWarn, 0);
  endtask

  task automatic testThermal();
    tsdFlag = 1'b1;
    cyc(1);
    chk(overTemp && killAll && supplyFail && shortSeen && tempWarn, "R9 forced",
        {overTemp, killAll, supplyFail, shortSeen, tempWarn}, 5'h1f);
    pulseReset();
    chk(overTemp == 1 && killAll == 1, "R10 reset while hot", {overTemp, killAll}, 3);
    tsdFlag = 1'b0;
    cyc(3);
    chk(overTemp == 1 && killAll == 1, "R10 cooled not released", {overTemp, killAll}, 3);
    pulseReset();
    chk(overTemp == 0 && killAll == 0 && supplyFail == 0 && shortSeen == 0 && tempWarn == 0,
        "R10 released", {overTemp, killAll, supplyFail, shortSeen, tempWarn}, 0);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    testReset();
    testUv();
    testShortHs();
    testShortLong();
    testGlitch();
    testTp();
    testThermal();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule